// File: doc/BRIEF.md
# Page TLB with Subpage Bitmaps

This block is a small, fully associative translation buffer in front of a large set-associative DRAM main memory that holds big pages. A request carries a virtual page number, an address space identifier and a subpage index. A single lookup answers two questions. The first is whether the page is resident, and if so in which entry and which DRAM frame. The second is whether the requested subpage is already valid in that frame, and whether it is dirty.

Only the tag, made of the address space identifier and the page number, is compared associatively. The per-page subpage status is kept in a separate store that is addressed by the index of the matching entry. Each page carries one valid bit and one dirty bit for every subpage.

Outside logic installs pages through a fill port. It reports completed subpage fetches, processor writes and page evictions through an update port. A hit is answered one cycle after the request. A miss is reported four cycles after the request, to an external handler that walks the tag array.

Top module: `subpage_tlb`

## Requirements
- R1: While reset is high, and in the cycle after it falls, hit_vld and miss_vld are 0. After reset no entry is resident, so every lookup misses.
- R2: A lookup whose page number and address space identifier both equal those of a resident entry raises hit_vld exactly one cycle after the request. It also gives that entry's index on hit_idx and its frame on hit_frame. A lookup that matches only one of the two fields misses.
- R3: A lookup that finds no resident entry raises miss_vld exactly four cycles after the request, with the requested page number and identifier on miss_vpn and miss_asid. No hit_vld is produced for it.
- R4: On a hit, hit_sub_valid and hit_sub_dirty give the valid and dirty bits of the subpage named by lk_sub. Subpage indices run from 0 to SUBPAGES-1.
- R5: An update with code 1 (subpage fetched) on a resident page sets that subpage's valid bit and clears its dirty bit.
- R6: An update with code 2 (write) on a resident page sets the dirty bit of the named subpage if that subpage is valid. If the subpage is not valid, the update has no effect. A dirty bit is never reported without its valid bit.
- R7: An update with code 3 (evict) removes a resident page, so later lookups of it miss. A later fill of the same page reports every subpage invalid.
- R8: A fill of a page that is not resident goes to the lowest-numbered empty entry. When no entry is empty, it goes to the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each fill placed this way.
- R9: A fill of a page that is already resident reuses its entry. It replaces the frame and clears all of that page's subpage bits.
- R10: A lookup in the same cycle as a fill or an update reports the state from before that fill or update.
- R11: When a fill and an update arrive in the same cycle, the update is ignored. Update code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address space identifier |
| lk_sub | input | SUB_W | Lookup subpage index |
| fill_en | input | 1 | Install a page |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_frame | input | FRAME_W | DRAM frame of the installed page |
| upd_op | input | 2 | 0 none, 1 subpage fetched, 2 write, 3 evict |
| upd_vpn | input | VPN_W | Update page number |
| upd_asid | input | ASID_W | Update identifier |
| upd_sub | input | SUB_W | Update subpage index |
| hit_vld | output | 1 | Lookup hit response |
| hit_idx | output | IDX_W | Entry index of the hit |
| hit_frame | output | FRAME_W | Frame of the hit page |
| hit_sub_valid | output | 1 | Requested subpage is valid |
| hit_sub_dirty | output | 1 | Requested subpage is dirty |
| miss_vld | output | 1 | Lookup miss report |
| miss_vpn | output | VPN_W | Page number that missed |
| miss_asid | output | ASID_W | Identifier that missed |

## Verification
The hardest state to reach from the ports is a full table, where placement moves from the empty-entry search to the round-robin pointer. A directed phase installs more distinct pages than there are entries. A random phase then draws keys from a pool larger than the table, mixed with evictions, so the pointer wraps while holes keep reopening. Same-cycle collisions are also hard to reach: a lookup against a fill or an update, and a fill against an update. Directed cycles drive those together, and the random phase produces them often because it chooses each port on its own.

// File: rtl/tlbsp_pkg.sv
package tlbsp_pkg;
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_SUBFILL = 2'd1,
    UPD_WRITE   = 2'd2,
    UPD_EVICT   = 2'd3
  } upd_op_e;
endpackage

// File: rtl/tlbsp_onehot_enc.sv
// Lowest-index encoder for a match or free vector.
module tlbsp_onehot_enc #(
  parameter int N = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlbsp_tag_cam.sv
// Associative tag store: valid bit, key and frame per entry.
module tlbsp_tag_cam #(
  parameter int ENTRIES = 64,
  parameter int KEY_W   = 28,
  parameter int FRAME_W = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [KEY_W-1:0]   lk_key,
  input  logic [KEY_W-1:0]   upd_key,
  input  logic [KEY_W-1:0]   fill_key,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               inv_en,
  input  logic [IDX_W-1:0]   inv_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [ENTRIES-1:0] lk_match,
  output logic [ENTRIES-1:0] upd_match,
  output logic [ENTRIES-1:0] fill_match,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_en && wr_idx == IDX_W'(e)) begin
          vld_q[e] <= 1'b1;
        end else if (inv_en && inv_idx == IDX_W'(e)) begin
          vld_q[e] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_idx]   <= fill_key;
      frame_q[wr_idx] <= wr_frame;
    end
  end

  assign rd_frame  = frame_q[rd_idx];
  assign valid_vec = vld_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_match[e]   = vld_q[e] && (key_q[e] == lk_key);
    assign upd_match[e]  = vld_q[e] && (key_q[e] == upd_key);
    assign fill_match[e] = vld_q[e] && (key_q[e] == fill_key);
  end
endmodule

// File: rtl/tlbsp_victim.sv
// Fill placement: resident entry, else first empty, else round robin.
module tlbsp_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  input  logic               fill_any,
  input  logic [IDX_W-1:0]   fill_idx,
  output logic [IDX_W-1:0]   vic_idx
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;

  tlbsp_onehot_enc #(.N(ENTRIES)) u_free_enc (
    .vec (~valid_vec),
    .any (free_any),
    .idx (free_idx)
  );

  always_comb begin
    if (fill_any)      vic_idx = fill_idx;
    else if (free_any) vic_idx = free_idx;
    else               vic_idx = rr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fill_en && !fill_any && !free_any) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else                             rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlbsp_bitmap.sv
// Subpage status rows: {dirty bits, valid bits} per entry.
// Asynchronous read and synchronous write (distributed RAM).
module tlbsp_bitmap #(
  parameter int ENTRIES = 64,
  parameter int ROW_W   = 128,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [ROW_W-1:0] rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [ROW_W-1:0] rd_b,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] wr_row
);
  logic [ROW_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_row;
  end

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];
endmodule

// File: rtl/tlbsp_miss_pipe.sv
// Delay line that holds back miss reports by LAT cycles.
module tlbsp_miss_pipe #(
  parameter int LAT = 4,
  parameter int W   = 28
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);
  logic [LAT-1:0] v_q;
  logic [W-1:0]   d_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int k = 0; k < LAT; k++) d_q[k] <= '0;
    end else begin
      v_q[0] <= in_vld;
      d_q[0] <= in_data;
      for (int k = 1; k < LAT; k++) begin
        v_q[k] <= v_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  end

  assign out_vld  = v_q[LAT-1];
  assign out_data = d_q[LAT-1];
endmodule

// File: rtl/subpage_tlb.sv
module subpage_tlb
  import tlbsp_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int VPN_W    = 20,
  parameter int ASID_W   = 8,
  parameter int FRAME_W  = 16,
  parameter int SUBPAGES = 64,
  parameter int MISS_LAT = 4,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SUB_W   = (SUBPAGES > 1) ? $clog2(SUBPAGES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_req,
  input  logic [VPN_W-1:0]   lk_vpn,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [SUB_W-1:0]   lk_sub,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [1:0]         upd_op,
  input  logic [VPN_W-1:0]   upd_vpn,
  input  logic [ASID_W-1:0]  upd_asid,
  input  logic [SUB_W-1:0]   upd_sub,
  output logic               hit_vld,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [FRAME_W-1:0] hit_frame,
  output logic               hit_sub_valid,
  output logic               hit_sub_dirty,
  output logic               miss_vld,
  output logic [VPN_W-1:0]   miss_vpn,
  output logic [ASID_W-1:0]  miss_asid
);
  localparam int KEY_W = VPN_W + ASID_W;
  localparam int ROW_W = 2 * SUBPAGES;

  upd_op_e            op;
  logic [KEY_W-1:0]   lk_key, upd_key, fill_key;
  logic [ENTRIES-1:0] lk_match, upd_match, fill_match, valid_vec;
  logic               lk_any, upd_any, fill_any;
  logic [IDX_W-1:0]   lk_idx, upd_idx, fill_idx, vic_idx;
  logic [FRAME_W-1:0] lk_frame;
  logic [ROW_W-1:0]   lk_row, upd_row, new_row, bm_row;
  logic [SUBPAGES-1:0] lk_v, lk_d, nv, nd;
  logic               upd_do, bm_we, inv_en;
  logic [IDX_W-1:0]   bm_idx;
  logic [KEY_W-1:0]   miss_key;

  assign op       = upd_op_e'(upd_op);
  assign lk_key   = {lk_asid, lk_vpn};
  assign upd_key  = {upd_asid, upd_vpn};
  assign fill_key = {fill_asid, fill_vpn};

  tlbsp_tag_cam #(
    .ENTRIES (ENTRIES),
    .KEY_W   (KEY_W),
    .FRAME_W (FRAME_W)
  ) u_cam (
    .clk        (clk),
    .rst        (rst),
    .lk_key     (lk_key),
    .upd_key    (upd_key),
    .fill_key   (fill_key),
    .wr_en      (fill_en),
    .wr_idx     (vic_idx),
    .wr_frame   (fill_frame),
    .inv_en     (inv_en),
    .inv_idx    (upd_idx),
    .rd_idx     (lk_idx),
    .rd_frame   (lk_frame),
    .lk_match   (lk_match),
    .upd_match  (upd_match),
    .fill_match (fill_match),
    .valid_vec  (valid_vec)
  );

  tlbsp_onehot_enc #(.N(ENTRIES)) u_lk_enc (
    .vec (lk_match), .any (lk_any), .idx (lk_idx)
  );
  tlbsp_onehot_enc #(.N(ENTRIES)) u_upd_enc (
    .vec (upd_match), .any (upd_any), .idx (upd_idx)
  );
  tlbsp_onehot_enc #(.N(ENTRIES)) u_fill_enc (
    .vec (fill_match), .any (fill_any), .idx (fill_idx)
  );

  tlbsp_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst       (rst),
    .valid_vec (valid_vec),
    .fill_en   (fill_en),
    .fill_any  (fill_any),
    .fill_idx  (fill_idx),
    .vic_idx   (vic_idx)
  );

  // Fill has priority: an update in a fill cycle is dropped.
  assign upd_do = !fill_en && upd_any && (op != UPD_NONE);
  assign inv_en = upd_do && (op == UPD_EVICT);

  always_comb begin
    nv = upd_row[SUBPAGES-1:0];
    nd = upd_row[ROW_W-1:SUBPAGES];
    case (op)
      UPD_SUBFILL: begin
        nv[upd_sub] = 1'b1;
        nd[upd_sub] = 1'b0;
      end
      UPD_WRITE: begin
        if (nv[upd_sub]) nd[upd_sub] = 1'b1;
      end
      UPD_EVICT: begin
        nv = '0;
        nd = '0;
      end
      default: begin
      end
    endcase
    new_row = {nd, nv};
  end

  assign bm_we  = fill_en || upd_do;
  assign bm_idx = fill_en ? vic_idx : upd_idx;
  assign bm_row = fill_en ? '0 : new_row;

  tlbsp_bitmap #(
    .ENTRIES (ENTRIES),
    .ROW_W   (ROW_W)
  ) u_bitmap (
    .clk      (clk),
    .rd_a_idx (lk_idx),
    .rd_a     (lk_row),
    .rd_b_idx (upd_idx),
    .rd_b     (upd_row),
    .we       (bm_we),
    .wr_idx   (bm_idx),
    .wr_row   (bm_row)
  );

  assign lk_v = lk_row[SUBPAGES-1:0];
  assign lk_d = lk_row[ROW_W-1:SUBPAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vld       <= 1'b0;
      hit_idx       <= '0;
      hit_frame     <= '0;
      hit_sub_valid <= 1'b0;
      hit_sub_dirty <= 1'b0;
    end else begin
      hit_vld       <= lk_req && lk_any;
      hit_idx       <= lk_idx;
      hit_frame     <= lk_frame;
      hit_sub_valid <= lk_req && lk_any && lk_v[lk_sub];
      hit_sub_dirty <= lk_req && lk_any && lk_d[lk_sub];
    end
  end

  tlbsp_miss_pipe #(
    .LAT (MISS_LAT),
    .W   (KEY_W)
  ) u_miss (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (lk_req && !lk_any),
    .in_data  (lk_key),
    .out_vld  (miss_vld),
    .out_data (miss_key)
  );

  assign miss_vpn  = miss_key[VPN_W-1:0];
  assign miss_asid = miss_key[KEY_W-1:VPN_W];
endmodule

// File: rtl/subpage_tlb_chk.sv
module subpage_tlb_chk #(
  parameter int VPN_W    = 20,
  parameter int ASID_W   = 8,
  parameter int FRAME_W  = 16,
  parameter int MISS_LAT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               lk_req,
  input logic [VPN_W-1:0]   lk_vpn,
  input logic [ASID_W-1:0]  lk_asid,
  input logic               fill_en,
  input logic [VPN_W-1:0]   fill_vpn,
  input logic [ASID_W-1:0]  fill_asid,
  input logic [FRAME_W-1:0] fill_frame,
  input logic [1:0]         upd_op,
  input logic [VPN_W-1:0]   upd_vpn,
  input logic [ASID_W-1:0]  upd_asid,
  input logic               hit_vld,
  input logic [FRAME_W-1:0] hit_frame,
  input logic               hit_sub_valid,
  input logic               hit_sub_dirty,
  input logic               miss_vld
);
  logic [MISS_LAT-1:0] req_h, hit_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_h <= '0;
      hit_h <= '0;
    end else begin
      req_h <= {req_h[MISS_LAT-2:0], lk_req};
      hit_h <= {hit_h[MISS_LAT-2:0], hit_vld};
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (!hit_vld && !miss_vld)); // R1

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    hit_vld |-> $past(lk_req)); // R2

  AST_MISS_TIMING: assert property (@(posedge clk) disable iff (rst)
    miss_vld |-> (req_h[MISS_LAT-1] && !hit_h[MISS_LAT-2])); // R3

  AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && hit_sub_dirty) |-> hit_sub_valid); // R6

  AST_EVICT_THEN_MISS: assert property (@(posedge clk) disable iff (rst)
    ($past(upd_op) == 2'd3 && !$past(fill_en) && lk_req &&
     lk_vpn == $past(upd_vpn) && lk_asid == $past(upd_asid)) |=> !hit_vld); // R7

  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_en) && lk_req && lk_vpn == $past(fill_vpn) &&
     lk_asid == $past(fill_asid)) |=>
    (hit_vld && !hit_sub_valid && hit_frame == $past(fill_frame, 2))); // R9
endmodule

bind subpage_tlb subpage_tlb_chk #(
  .VPN_W    (VPN_W),
  .ASID_W   (ASID_W),
  .FRAME_W  (FRAME_W),
  .MISS_LAT (MISS_LAT)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .lk_req        (lk_req),
  .lk_vpn        (lk_vpn),
  .lk_asid       (lk_asid),
  .fill_en       (fill_en),
  .fill_vpn      (fill_vpn),
  .fill_asid     (fill_asid),
  .fill_frame    (fill_frame),
  .upd_op        (upd_op),
  .upd_vpn       (upd_vpn),
  .upd_asid      (upd_asid),
  .hit_vld       (hit_vld),
  .hit_frame     (hit_frame),
  .hit_sub_valid (hit_sub_valid),
  .hit_sub_dirty (hit_sub_dirty),
  .miss_vld      (miss_vld)
);

// File: tb/subpage_tlb_tb_top.sv
module subpage_tlb_tb_top;
  localparam int E  = 64;
  localparam int VW = 20;
  localparam int AW = 8;
  localparam int FW = 16;
  localparam int SP = 64;
  localparam int ML = 4;
  localparam int IW = 6;
  localparam int SW = 6;
  localparam int KW = VW + AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          lk_req = 0;
  logic [VW-1:0] lk_vpn = 0;
  logic [AW-1:0] lk_asid = 0;
  logic [SW-1:0] lk_sub = 0;
  logic          fill_en = 0;
  logic [VW-1:0] fill_vpn = 0;
  logic [AW-1:0] fill_asid = 0;
  logic [FW-1:0] fill_frame = 0;
  logic [1:0]    upd_op = 0;
  logic [VW-1:0] upd_vpn = 0;
  logic [AW-1:0] upd_asid = 0;
  logic [SW-1:0] upd_sub = 0;
  logic          hit_vld, hit_sub_valid, hit_sub_dirty, miss_vld;
  logic [IW-1:0] hit_idx;
  logic [FW-1:0] hit_frame;
  logic [VW-1:0] miss_vpn;
  logic [AW-1:0] miss_asid;

  always #5 clk = ~clk;

  subpage_tlb dut_i (
    .clk (clk), .rst (rst),
    .lk_req (lk_req), .lk_vpn (lk_vpn), .lk_asid (lk_asid), .lk_sub (lk_sub),
    .fill_en (fill_en), .fill_vpn (fill_vpn), .fill_asid (fill_asid),
    .fill_frame (fill_frame),
    .upd_op (upd_op), .upd_vpn (upd_vpn), .upd_asid (upd_asid), .upd_sub (upd_sub),
    .hit_vld (hit_vld), .hit_idx (hit_idx), .hit_frame (hit_frame),
    .hit_sub_valid (hit_sub_valid), .hit_sub_dirty (hit_sub_dirty),
    .miss_vld (miss_vld), .miss_vpn (miss_vpn), .miss_asid (miss_asid)
  );

  // Reference model
  bit            m_v  [E];
  logic [KW-1:0] m_key[E];
  logic [FW-1:0] m_fr [E];
  logic [SP-1:0] m_bv [E];
  logic [SP-1:0] m_bd [E];
  int            m_rr;

  bit            e_hit;
  int            e_idx;
  logic [FW-1:0] e_fr;
  bit            e_sv, e_sd;
  bit            mq_v  [ML];
  logic [KW-1:0] mq_key[ML];

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 0;
  string tag   = "R1";

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int find(logic [KW-1:0] k);
    for (int i = 0; i < E; i++) if (m_v[i] && m_key[i] == k) return i;
    return -1;
  endfunction

  task automatic check_outputs();
    chk("hit_vld", 64'(hit_vld), 64'(e_hit));
    if (e_hit) begin
      chk("hit_idx", 64'(hit_idx), 64'(e_idx));
      chk("hit_frame", 64'(hit_frame), 64'(e_fr));
      chk("hit_sub_valid", 64'(hit_sub_valid), 64'(e_sv));
      chk("hit_sub_dirty", 64'(hit_sub_dirty), 64'(e_sd));
    end
    chk("miss_vld", 64'(miss_vld), 64'(mq_v[ML-1]));
    if (mq_v[ML-1]) chk("miss_key", 64'({miss_asid, miss_vpn}), 64'(mq_key[ML-1]));
  endtask

  task automatic cyc(input bit lk, input int lv, input int la, input int ls,
                     input bit fl, input int fv, input int fa, input int ff,
                     input int op, input int uv, input int ua, input int us);
    logic [KW-1:0] lkey, fkey, ukey;
    int i;
    int vic;
    @(negedge clk);
    check_outputs();
    lkey = {AW'(la), VW'(lv)};
    fkey = {AW'(fa), VW'(fv)};
    ukey = {AW'(ua), VW'(uv)};
    // lookup sees state before this cycle's changes (R10)
    e_hit = 0;
    for (int k = ML - 1; k > 0; k--) begin
      mq_v[k] = mq_v[k-1];
      mq_key[k] = mq_key[k-1];
    end
    mq_v[0] = 0;
    mq_key[0] = lkey;
    if (lk) begin
      i = find(lkey);
      if (i >= 0) begin
        e_hit = 1; e_idx = i; e_fr = m_fr[i];
        e_sv = m_bv[i][ls]; e_sd = m_bd[i][ls];
      end else begin
        mq_v[0] = 1;
      end
    end
    if (fl) begin
      i = find(fkey);
      vic = i;
      if (vic < 0) for (int j = 0; j < E; j++) if (!m_v[j] && vic < 0) vic = j;
      if (vic < 0) begin vic = m_rr; m_rr = (m_rr + 1) % E; end
      m_v[vic] = 1; m_key[vic] = fkey; m_fr[vic] = FW'(ff);
      m_bv[vic] = '0; m_bd[vic] = '0;
    end else if (op != 0) begin
      i = find(ukey);
      if (i >= 0) begin
        case (op)
          1: begin m_bv[i][us] = 1'b1; m_bd[i][us] = 1'b0; end
          2: if (m_bv[i][us]) m_bd[i][us] = 1'b1;
          default: begin m_v[i] = 0; m_bv[i] = '0; m_bd[i] = '0; end
        endcase
      end
    end
    lk_req = lk; lk_vpn = VW'(lv); lk_asid = AW'(la); lk_sub = SW'(ls);
    fill_en = fl; fill_vpn = VW'(fv); fill_asid = AW'(fa); fill_frame = FW'(ff);
    upd_op = 2'(op); upd_vpn = VW'(uv); upd_asid = AW'(ua); upd_sub = SW'(us);
  endtask

  task automatic do_lk(input int v, input int a, input int s);
    cyc(1, v, a, s, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic do_fill(input int v, input int a, input int f);
    cyc(0, 0, 0, 0, 1, v, a, f, 0, 0, 0, 0);
  endtask
  task automatic do_upd(input int op, input int v, input int a, input int s);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, op, v, a, s);
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < E; i++) begin
      m_v[i] = 0; m_key[i] = '0; m_fr[i] = '0; m_bv[i] = '0; m_bd[i] = '0;
    end
    for (int k = 0; k < ML; k++) begin mq_v[k] = 0; mq_key[k] = '0; end
    m_rr = 0; e_hit = 0;

    // R1: quiet outputs while in reset
    tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset hit_vld", 64'(hit_vld), 64'd0);
    chk("reset miss_vld", 64'(miss_vld), 64'd0);
    rst = 1'b0;
    do_lk(5, 1, 0);
    do_lk(7, 0, 0);
    idle(4);

    // R2 / R3: hit needs both fields, miss after four cycles
    tag = "R2";
    do_fill(5, 1, 16'h0055);
    do_lk(5, 1, 0);
    tag = "R3";
    do_lk(5, 2, 0);
    do_lk(6, 1, 0);
    idle(4);

    // R4 / R5: subpage fetch sets valid, top index included
    tag = "R5";
    do_upd(1, 5, 1, 3);
    do_upd(1, 5, 1, 63);
    tag = "R4";
    do_lk(5, 1, 3);
    do_lk(5, 1, 4);
    do_lk(5, 1, 63);

    // R6: write marks valid subpage dirty, invalid subpage untouched
    tag = "R6";
    do_upd(2, 5, 1, 3);
    do_upd(2, 5, 1, 9);
    do_lk(5, 1, 3);
    do_lk(5, 1, 9);
    tag = "R5";
    do_upd(1, 5, 1, 3);
    do_lk(5, 1, 3);

    // R10: same-cycle lookup against fill and against update
    tag = "R10";
    cyc(1, 8, 1, 0, 1, 8, 1, 16'h0088, 0, 0, 0, 0);
    do_lk(8, 1, 0);
    cyc(1, 5, 1, 20, 0, 0, 0, 0, 1, 5, 1, 20);
    do_lk(5, 1, 20);

    // R11: update dropped in a fill cycle; code 0 inert
    tag = "R11";
    cyc(0, 0, 0, 0, 1, 9, 1, 16'h0099, 1, 5, 1, 21);
    do_lk(5, 1, 21);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 5, 1, 3);
    do_lk(5, 1, 3);

    // R7: eviction, then refill shows empty bitmap
    tag = "R7";
    do_upd(3, 5, 1, 0);
    do_lk(5, 1, 3);
    do_fill(5, 1, 16'h0155);
    do_lk(5, 1, 3);
    do_lk(5, 1, 63);
    idle(4);

    // R9: refill of a resident page
    tag = "R9";
    do_upd(1, 8, 1, 2);
    do_fill(8, 1, 16'h0888);
    do_lk(8, 1, 2);

    // R8: overflow the table so the round-robin pointer takes over
    tag = "R8";
    for (int k = 0; k < E + 8; k++) begin
      do_fill(100 + k, 3, 16'h1000 + k);
      do_lk(100 + k, 3, 0);
    end
    do_upd(3, 130, 3, 0);
    do_fill(999, 4, 16'h0999);
    do_lk(999, 4, 0);
    idle(4);

    // Random mix over a key pool larger than the table
    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      bit lk, fl;
      int op, s1, s2;
      lk = ($urandom % 10) < 7;
      fl = ($urandom % 10) < 2;
      op = (($urandom % 10) < 5) ? int'($urandom % 4) : 0;
      s1 = (($urandom % 16) == 0) ? 63 : int'($urandom % 8);
      s2 = (($urandom % 16) == 0) ? 63 : int'($urandom % 8);
      cyc(lk, int'($urandom % 48), int'($urandom % 2), s1,
          fl, int'($urandom % 48), int'($urandom % 2), int'($urandom % 65536),
          op, int'($urandom % 48), int'($urandom % 2), s2);
    end
    idle(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule